// File: doc/BRIEF.md
# Output Compare Unit with Group Mask

This block holds the compare side of a general purpose timer. Eight channels watch one shared free-running count supplied from outside. Each channel keeps a compare value. When the count reaches that value on an advancing cycle, the channel latches a flag, can raise an interrupt, and acts on its output pin. A per-channel mode bit chooses between compare use and capture use. In capture use the channel does nothing here, because capture logic lives elsewhere.

The lower channels each own one pin and apply a two-bit action to it. The last channel is a group channel. On a match it loads any chosen subset of all pins from a data word, in one cycle. Software can force the pin action of any channel without a match. A match on the group channel can also request that the timer clear its count.

Top module: `oc_mask_unit`

## Requirements
- R1: Writing `cmp_wdata_i` with bit n of `cmp_we_i` set stores the compare value of channel n. A channel in compare mode (`oc_mode_i[n]`=1) matches on a clock edge where `cnt_tick_i`=1 and `cnt_i` equals its stored value. A write in the same cycle as a match affects only later cycles.
- R2: A match sets `flag_o[n]` at that clock edge. The flag stays set until a cycle with `flag_clr_i[n]`=1 and no new match. If a match and a clear occur in the same cycle, the set wins.
- R3: `irq_o[n]` is high exactly while `flag_o[n]` and `irq_en_i[n]` are both high.
- R4: Each channel n below the last has an event on a match or an accepted force. On that event it updates `pin_o[n]` at the clock edge, using `act_i[2n+1:2n]`: 00 leaves the pin alone, 01 inverts it, 10 drives 0, 11 drives 1. With no event the pin holds.
- R5: An event on the last channel loads every pin k with `grp_mask_i[k]`=1 from `grp_data_i[k]`, all at the same edge. Pins with a mask bit of 0 are not touched by it.
- R6: When the last channel and channel n both act on pin n in the same cycle, the value from `grp_data_i` wins.
- R7: `force_i[n]`=1 on a channel in compare mode performs that channel's pin action at the next edge, as an event would. It never sets `flag_o[n]`.
- R8: A channel in capture mode (`oc_mode_i[n]`=0) never matches and ignores `force_i[n]`. Its flag is not set and it drives no pin.
- R9: `cnt_rst_o` pulses high for one cycle, at the edge where the last channel matches, when `cnt_rst_en_i`=1. Otherwise it stays low.
- R10: No channel matches in a cycle with `cnt_tick_i`=0, whatever the count.
- R11: After reset, `pin_o`, `flag_o`, `irq_o` and `cnt_rst_o` are all 0, and every stored compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Shared free-running count |
| cnt_tick_i | input | 1 | Count is valid and advancing this cycle |
| oc_mode_i | input | 8 | Per-channel mode: 1 compare, 0 capture |
| act_i | input | 14 | Two-bit pin action for each single-pin channel |
| irq_en_i | input | 8 | Per-channel interrupt enable |
| grp_mask_i | input | 8 | Pins driven by the group channel |
| grp_data_i | input | 8 | Values loaded by the group channel |
| cnt_rst_en_i | input | 1 | Allow a count clear on a group match |
| cmp_we_i | input | 8 | Per-channel compare value write strobe |
| cmp_wdata_i | input | 16 | Compare value write data |
| force_i | input | 8 | Software forced event, one per channel |
| flag_clr_i | input | 8 | Write-one-to-clear for the flags |
| flag_o | output | 8 | Match flags |
| irq_o | output | 8 | Interrupt requests |
| pin_o | output | 8 | Output pins |
| cnt_rst_o | output | 1 | Count clear request |

## Verification
The bench builds the block with its default eight channels and 16-bit count. It keeps the count inside a window of 32 values, so random compare values match often. Because matches are frequent, group and single-pin events land in the same cycle, and sets and clears collide on one flag. Capture-mode channels also receive forces and matching counts. A behavioural model checks the pins, flags, interrupts and count-clear request every cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;
endpackage

// File: rtl/oc_chan.sv
module oc_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic             mode_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             force_i,
  output logic             match_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (we_i) cmp_q <= wdata_i;
  end

  assign match_o = tick_i & mode_i & (cnt_i == cmp_q);
  assign event_o = match_o | (force_i & mode_i);

  // R10
  no_idle_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !match_o);
endmodule

// File: rtl/oc_flags.sv
module oc_flags #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] irq_en_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R2
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_q[k]);
    // R2
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[k] && !clr_i[k] |=> flag_q[k]);
    // R2
    flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_q[k] && !set_i[k] |=> !flag_q[k]);
  end
endmodule

// File: rtl/oc_pin_ctl.sv
module oc_pin_ctl
  import oc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     event_i,
  input  logic [2*N-3:0]   act_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     data_i,
  output logic [N-1:0]     pin_o
);
  localparam int LAST = N - 1;

  logic [N-1:0] pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    for (int k = 0; k < LAST; k++) begin
      if (event_i[k]) begin
        case (pin_act_e'(act_i[2*k +: 2]))
          ACT_TOGGLE: pin_d[k] = ~pin_q[k];
          ACT_LOW:    pin_d[k] = 1'b0;
          ACT_HIGH:   pin_d[k] = 1'b1;
          default:    pin_d[k] = pin_q[k];
        endcase
      end
    end
    // group channel overrides single-pin actions
    if (event_i[LAST]) pin_d = (pin_d & ~mask_i) | (data_i & mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R6
    grp_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[LAST] && mask_i[k] |=> pin_q[k] == $past(data_i[k]));
    if (k < LAST) begin : g_single
      // R4
      pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !event_i[k] && !(event_i[LAST] && mask_i[k]) |=> $stable(pin_q[k]));
    end else begin : g_last
      // R5
      grp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(event_i[LAST] && mask_i[k]) |=> $stable(pin_q[k]));
    end
  end
endmodule

// File: rtl/oc_mask_unit.sv
module oc_mask_unit #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    cnt_tick_i,
  input  logic [NUM_CH-1:0]       oc_mode_i,
  input  logic [2*NUM_CH-3:0]     act_i,
  input  logic [NUM_CH-1:0]       irq_en_i,
  input  logic [NUM_CH-1:0]       grp_mask_i,
  input  logic [NUM_CH-1:0]       grp_data_i,
  input  logic                    cnt_rst_en_i,
  input  logic [NUM_CH-1:0]       cmp_we_i,
  input  logic [CNT_W-1:0]        cmp_wdata_i,
  input  logic [NUM_CH-1:0]       force_i,
  input  logic [NUM_CH-1:0]       flag_clr_i,
  output logic [NUM_CH-1:0]       flag_o,
  output logic [NUM_CH-1:0]       irq_o,
  output logic [NUM_CH-1:0]       pin_o,
  output logic                    cnt_rst_o
);
  localparam int LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] match, evt;
  logic              cnt_rst_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    oc_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt_i),
      .tick_i  (cnt_tick_i),
      .mode_i  (oc_mode_i[n]),
      .we_i    (cmp_we_i[n]),
      .wdata_i (cmp_wdata_i),
      .force_i (force_i[n]),
      .match_o (match[n]),
      .event_o (evt[n])
    );
  end

  oc_flags #(.N(NUM_CH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (match),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  oc_pin_ctl #(.N(NUM_CH)) u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (evt),
    .act_i   (act_i),
    .mask_i  (grp_mask_i),
    .data_i  (grp_data_i),
    .pin_o   (pin_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_rst_q <= 1'b0;
    else         cnt_rst_q <= match[LAST] & cnt_rst_en_i;
  end
  assign cnt_rst_o = cnt_rst_q;

  // R9
  cnt_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |-> $past(match[LAST] && cnt_rst_en_i));
  // R9
  cnt_rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[LAST] && cnt_rst_en_i |=> cnt_rst_o);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R7
    force_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_i[n] && !match[n] && !flag_o[n] |=> !flag_o[n]);
    // R8
    capture_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oc_mode_i[n] |-> !evt[n]);
    // R3
    irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> flag_o[n]);
  end
endmodule

// File: tb/oc_mask_unit_tb.sv
`timescale 1ns/1ps
module oc_mask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        tick = 1'b0;
  logic [7:0]  oc_mode = '0;
  logic [13:0] act = '0;
  logic [7:0]  irq_en = '0, gmask = '0, gdata = '0;
  logic        rst_en = 1'b0;
  logic [7:0]  cmp_we = '0;
  logic [15:0] cmp_wd = '0;
  logic [7:0]  frc = '0, fclr = '0;
  logic [7:0]  flag_o, irq_o, pin_o;
  logic        cnt_rst_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  oc_mask_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt_i), .cnt_tick_i(tick),
    .oc_mode_i(oc_mode), .act_i(act), .irq_en_i(irq_en),
    .grp_mask_i(gmask), .grp_data_i(gdata), .cnt_rst_en_i(rst_en),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd), .force_i(frc),
    .flag_clr_i(fclr), .flag_o(flag_o), .irq_o(irq_o), .pin_o(pin_o),
    .cnt_rst_o(cnt_rst_o)
  );

  // behavioural reference
  int       cmp_m [8];
  bit [7:0] flag_m, pin_m;
  bit       crst_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (cmp_m[i]) cmp_m[i] = 0;
      flag_m = '0; pin_m = '0; crst_m = 1'b0;
    end else begin
      bit [7:0] hit, ev;
      bit [7:0] nxt;
      for (int i = 0; i < 8; i++) begin
        hit[i] = oc_mode[i] && tick && (int'(cnt_i) == cmp_m[i]);
        ev[i]  = hit[i] || (frc[i] && oc_mode[i]);
      end
      nxt = pin_m;
      for (int i = 0; i < 7; i++)
        if (ev[i]) begin
          int a;
          a = act[2*i +: 2];
          if (a == 1) nxt[i] = !pin_m[i];
          else if (a == 2) nxt[i] = 1'b0;
          else if (a == 3) nxt[i] = 1'b1;
        end
      if (ev[7])
        for (int i = 0; i < 8; i++) if (gmask[i]) nxt[i] = gdata[i];
      pin_m  = nxt;
      flag_m = hit | (flag_m & ~fclr);
      crst_m = hit[7] && rst_en;
      for (int i = 0; i < 8; i++) if (cmp_we[i]) cmp_m[i] = int'(cmp_wd);
    end
  end

  task automatic chk(input string tag, input int actv, input int expv);
    n_chk++;
    if (actv != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actv, expv, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R4 R5 R6 R7 R8 pins", pin_o, pin_m);
    chk("R1 R2 R8 R10 flags", flag_o, flag_m);
    chk("R3 irq", irq_o, flag_m & irq_en);
    chk("R9 cnt_rst", cnt_rst_o, crst_m);
  end

  task automatic step();
    @(posedge clk); #1;
    cmp_we = '0; frc = '0; fclr = '0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R11 reset pins", pin_o, 0);
    chk("R11 reset flags", flag_o, 0);
    chk("R11 reset cnt_rst", cnt_rst_o, 0);

    // ch0: compare 5, drive high
    cmp_we = 8'h01; cmp_wd = 16'd5; step();
    oc_mode = 8'h01; act[1:0] = 2'b11; cnt_i = 16'd5; tick = 1'b0; step();
    chk("R10 no tick no match", pin_o[0], 0);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R1 R4 pin0 high", pin_o[0], 1);
    chk("R2 flag0 set", flag_o[0], 1);
    irq_en = 8'h01; #1;
    chk("R3 irq0", irq_o[0], 1);
    fclr = 8'h01; step();
    chk("R2 flag0 cleared", flag_o[0], 0);
    chk("R3 irq0 low", irq_o[0], 0);
    act[1:0] = 2'b01; frc = 8'h01; step();
    chk("R7 force toggle", pin_o[0], 0);
    chk("R7 force no flag", flag_o[0], 0);
    act[1:0] = 2'b11; frc = 8'h01; step();
    act[1:0] = 2'b10; frc = 8'h01; step();
    chk("R4 drive low", pin_o[0], 0);

    // group channel
    cmp_we = 8'h80; cmp_wd = 16'd9; step();
    oc_mode = 8'h81; gmask = 8'h0F; gdata = 8'h05; rst_en = 1'b1;
    cnt_i = 16'd9; tick = 1'b1; step(); tick = 1'b0;
    chk("R5 group load", pin_o[3:0], 4'h5);
    chk("R2 flag7", flag_o[7], 1);
    chk("R9 cnt_rst pulse", cnt_rst_o, 1);
    step();
    chk("R9 cnt_rst single", cnt_rst_o, 0);

    // priority on pin1
    cmp_we = 8'h82; cmp_wd = 16'd12; step();
    oc_mode = 8'h83; act[3:2] = 2'b11; gmask = 8'h02; gdata = 8'h00;
    cnt_i = 16'd12; tick = 1'b1; step(); tick = 1'b0;
    chk("R6 group wins", pin_o[1], 0);

    // capture-mode channel 2
    cmp_we = 8'h04; cmp_wd = 16'd15; step();
    act[5:4] = 2'b10; cnt_i = 16'd15; tick = 1'b1; frc = 8'h04; step(); tick = 1'b0;
    chk("R8 capture pin", pin_o[2], 1);
    chk("R8 capture flag", flag_o[2], 0);

    // random traffic against the model
    cnt_i = '0;
    for (int c = 0; c < 4000; c++) begin
      tick = ($urandom % 4) != 0;
      if (tick) cnt_i = (cnt_i + 16'd1) & 16'h1F;
      if ($urandom % 4 == 0) begin
        cmp_we = 8'h1 << ($urandom % 8); cmp_wd = 16'($urandom % 32);
      end
      if ($urandom % 6 == 0) frc = 8'($urandom) & 8'($urandom);
      if ($urandom % 5 == 0) fclr = 8'($urandom);
      if ($urandom % 20 == 0) act = 14'($urandom);
      if ($urandom % 40 == 0) oc_mode = 8'($urandom) | 8'h81;
      if ($urandom % 15 == 0) begin gmask = 8'($urandom); gdata = 8'($urandom); end
      if ($urandom % 25 == 0) irq_en = 8'($urandom);
      if ($urandom % 30 == 0) rst_en = !rst_en;
      step();
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule